// File: doc/BRIEF.md
# Change-Qualified Trace Capture Unit

This unit samples a parallel probe bus on every clock and writes samples into an on-chip ring of trace storage. In the change-qualified mode, a sample is written only when the channels picked by a mask differ from the last value written. Runs of identical samples therefore take no room, and the stored history covers more time when the data changes rarely. A second mode writes every clock, which gives plain synchronous capture.

Each written sample is paired with a timestamp from a free-running counter. The timestamps sit in a memory of their own, so they take no room from the sample data. A one-cycle `arm` pulse clears the ring, the counter and the reference value, then starts capture. A one-cycle `stop` pulse freezes capture. After that, a readback port walks the ring from the oldest entry to the newest. It returns each entry's timestamp either as an absolute count or as the gap since the previous entry.

Top module: `trace_capture`

## Requirements
- R1: The ring holds DEPTH entries. After more than DEPTH writes, `count` equals DEPTH and readback returns the newest DEPTH entries, oldest first.
- R2: With `trans_mode`=1, a running cycle writes only when `(probe ^ last_written) & grp_mask` is nonzero. A bus that changes once every four clocks fills one entry per four clocks.
- R3: A change only in bits where `grp_mask` is 0 never causes a write. A write records all W probe bits.
- R4: The first running cycle after `arm` always writes, even when `grp_mask` is all zeros.
- R5: With `trans_mode`=0, every running cycle writes one entry.
- R6: The timestamp counter is cleared by `arm` and counts every running clock. The first written entry carries 0, and the entry written k running clocks later carries k.
- R7: With `rd_rel`=1, `rd_ts` gives 0 for the oldest entry and, for each later entry, its timestamp minus that of the entry before it. With `rd_rel`=0, it gives the absolute timestamp.
- R8: The cycle on which `stop` is high writes nothing. While stopped, probe activity does not change `count` or the stored contents.
- R9: `arm` clears the entry count. In the cycle after `arm`, `count` is 0 and `running` is 1.
- R10: `rd_start` while stopped loads the oldest entry. Each `rd_next` with `rd_valid` high steps to the next-newer entry. `rd_valid` stays high for exactly `count` entries and is never high while running.
- R11: After reset, `running` is 0, `count` is 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Pulse: clear state and begin capture |
| stop | input | 1 | Pulse: end capture |
| trans_mode | input | 1 | 1 = write on masked change, 0 = write every clock |
| grp_mask | input | W | Channels that qualify a write |
| probe | input | W | Probed bus |
| rd_start | input | 1 | Pulse: begin readback at the oldest entry |
| rd_next | input | 1 | Advance readback by one entry |
| rd_rel | input | 1 | 1 = timestamps as gaps, 0 = absolute |
| running | output | 1 | Capture active |
| count | output | $clog2(DEPTH)+1 | Number of valid entries |
| rd_valid | output | 1 | Readback entry present |
| rd_data | output | W | Readback sample |
| rd_ts | output | TSW | Readback timestamp |

## Verification
The properties assume that `arm` and `stop` are single-cycle pulses, and that `grp_mask` and `trans_mode` change only while capture is stopped or in the same cycle as `arm`. The stimulus sets mode and mask in the arm cycle and holds them until the next arm. It moves `probe` only on falling edges, so the ports never see a change and a store in the same cycle. Readback runs only after `stop`, which keeps `rd_valid` apart from capture.

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int TSW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             stop,
  input  logic             trans_mode,
  input  logic [W-1:0]     grp_mask,
  input  logic [W-1:0]     probe,
  input  logic             rd_start,
  input  logic             rd_next,
  input  logic             rd_rel,
  output logic             running,
  output logic [$clog2(DEPTH):0] count,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data,
  output logic [TSW-1:0]   rd_ts
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]   data_mem [DEPTH];
  logic [TSW-1:0] ts_mem   [DEPTH];

  logic [AW-1:0]  wp, rp;
  logic [AW:0]    left;
  logic           full, first, run_q, rd_first;
  logic [W-1:0]   last;
  logic [TSW-1:0] ts;

  wire changed = |((probe ^ last) & grp_mask);
  wire store   = run_q && !stop && !arm && (first || !trans_mode || changed);

  assign running  = run_q;
  assign count    = full ? FULL_CNT : {1'b0, wp};
  assign rd_valid = !run_q && (left != '0);
  assign rd_data  = data_mem[rp];
  assign rd_ts    = !rd_rel  ? ts_mem[rp] :
                    rd_first ? '0 : ts_mem[rp] - ts_mem[rp - AW'(1)];

  always_ff @(posedge clk) begin
    if (store) begin
      data_mem[wp] <= probe;
      ts_mem[wp]   <= ts;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      wp    <= '0;
      full  <= 1'b0;
      first <= 1'b0;
      last  <= '0;
      ts    <= '0;
    end else if (arm) begin
      run_q <= 1'b1;
      wp    <= '0;
      full  <= 1'b0;
      first <= 1'b1;
      ts    <= '0;
    end else begin
      if (stop) run_q <= 1'b0;
      if (run_q) ts <= ts + TSW'(1);
      if (store) begin
        wp    <= wp + AW'(1);
        full  <= full | (wp == AW'(DEPTH-1));
        last  <= probe;
        first <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      rp       <= '0;
      left     <= '0;
      rd_first <= 1'b0;
    end else if (rd_start && !run_q) begin
      rp       <= full ? wp : '0;
      left     <= count;
      rd_first <= 1'b1;
    end else if (rd_next && rd_valid) begin
      rp       <= rp + AW'(1);
      left     <= left - (AW+1)'(1);
      rd_first <= 1'b0;
    end
  end
endmodule

module trace_capture_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  arm,
  input logic                  stop,
  input logic                  trans_mode,
  input logic [W-1:0]          grp_mask,
  input logic [W-1:0]          probe,
  input logic                  running,
  input logic [$clog2(DEPTH):0] count,
  input logic                  rd_valid
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_hold_when_unchanged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(arm) && !arm && !stop && trans_mode &&
     $stable(grp_mask) && ((probe ^ $past(probe)) & grp_mask) == '0)
    |=> $stable(count));

  p_first_after_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arm) && running && !arm && !stop) |=> count == CW'(1));

  p_every_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !arm && !stop && !trans_mode && count != CW'(DEPTH))
    |=> count == $past(count) + CW'(1));

  p_frozen_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !arm) |=> $stable(count));

  p_arm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (count == '0 && running));

  p_no_read_while_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !rd_valid);
endmodule

bind trace_capture trace_capture_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .trans_mode(trans_mode),
  .grp_mask(grp_mask), .probe(probe), .running(running), .count(count),
  .rd_valid(rd_valid)
);

// File: tb/trace_capture_tb.sv
module trace_capture_tb;
  localparam int W = 8, DEPTH = 16, TSW = 32;

  typedef struct packed { logic [W-1:0] d; logic [TSW-1:0] t; } entry_t;

  logic clk = 0, rst_n = 0;
  logic arm = 0, stop = 0, trans_mode = 1, rd_start = 0, rd_next = 0, rd_rel = 0;
  logic [W-1:0] grp_mask = '1, probe = '0;
  logic running, rd_valid;
  logic [$clog2(DEPTH):0] count;
  logic [W-1:0] rd_data;
  logic [TSW-1:0] rd_ts;

  trace_capture #(.W(W), .DEPTH(DEPTH), .TSW(TSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .trans_mode(trans_mode),
    .grp_mask(grp_mask), .probe(probe), .rd_start(rd_start), .rd_next(rd_next),
    .rd_rel(rd_rel), .running(running), .count(count), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ts(rd_ts)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  entry_t exp_q[$], saved[$];
  logic [W-1:0] m_last;
  logic m_first, m_mode, cap;
  logic [W-1:0] m_mask;
  longint tnow;
  logic mon_en = 0, mon_rel = 0, mon_first = 0;
  logic [TSW-1:0] mon_prev;
  string mon_req = "";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && rd_valid) begin
      entry_t e;
      logic [TSW-1:0] et;
      if (exp_q.size() == 0) begin
        chk(0, mon_req, "unexpected readback entry", rd_data, -1);
      end else begin
        e  = exp_q.pop_front();
        et = mon_rel ? (mon_first ? '0 : e.t - mon_prev) : e.t;
        chk(rd_data == e.d, mon_req, "rd_data", rd_data, e.d);
        chk(rd_ts == et, mon_req, "rd_ts", rd_ts, et);
        mon_prev  = e.t;
        mon_first = 0;
      end
    end
  end

  task automatic do_arm(input logic mode, input logic [W-1:0] mask);
    trans_mode = mode; grp_mask = mask; arm = 1;
    @(negedge clk);
    arm = 0;
    chk(count == 0 && running, "R9", "count after arm", count, 0);
    exp_q.delete();
    m_first = 1; m_mode = mode; m_mask = mask; tnow = 0; cap = 1;
  endtask

  task automatic apply(input logic [W-1:0] v, input int hold);
    probe = v;
    for (int i = 0; i < hold; i++) begin
      if (cap && (m_first || !m_mode || (((v ^ m_last) & m_mask) != 0))) begin
        exp_q.push_back('{d: v, t: TSW'(tnow)});
        m_last = v; m_first = 0;
      end
      @(negedge clk);
      tnow++;
    end
  endtask

  task automatic do_stop();
    stop = 1;
    @(negedge clk);
    stop = 0; cap = 0;
    while (exp_q.size() > DEPTH) void'(exp_q.pop_front());
    saved = exp_q;
  endtask

  task automatic readback(input logic rel, input string req);
    exp_q = saved;
    mon_req = req; mon_rel = rel; mon_first = 1; rd_rel = rel;
    chk(count == saved.size(), req, "count", count, saved.size());
    rd_start = 1; mon_en = 1;
    @(negedge clk);
    rd_start = 0; rd_next = 1;
    for (int i = 0; i < DEPTH + 4; i++) begin
      if (!rd_valid) break;
      @(negedge clk);
    end
    rd_next = 0; mon_en = 0;
    chk(exp_q.size() == 0, req, "entries left unread", exp_q.size(), 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    cap = 0; m_last = '0; m_first = 0; m_mode = 1; m_mask = '1; tnow = 0; mon_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!running && count == 0 && !rd_valid, "R11", "reset state", count, 0);

    // R2/R4/R6/R7: bus changes every four clocks, forty clocks total
    do_arm(1, 8'hFF);
    for (int k = 0; k < 10; k++) apply(8'(k * 37 + 5), 4);
    do_stop();
    chk(count == 10, "R2", "quarter of 40 samples stored", count, 10);
    readback(0, "R6");
    readback(1, "R7");

    // R8: probe activity while stopped
    for (int k = 0; k < 6; k++) apply(8'(k * 11 + 200), 2);
    chk(count == 10, "R8", "count after stopped activity", count, 10);
    readback(0, "R8");

    // R1: wrap after twenty stores
    do_arm(1, 8'hFF);
    for (int k = 0; k < 20; k++) apply(8'(k * 13 + 1), 4);
    do_stop();
    chk(count == DEPTH, "R1", "count full", count, DEPTH);
    readback(0, "R1");
    readback(1, "R1");

    // R3: masked-out bits
    do_arm(1, 8'h0F);
    apply(8'h11, 3); apply(8'h21, 3); apply(8'h22, 3);
    apply(8'hA2, 3); apply(8'h53, 3); apply(8'hF3, 3);
    do_stop();
    chk(count == 3, "R3", "stores under mask", count, 3);
    readback(0, "R3");

    // R4: zero mask still stores the first sample
    do_arm(1, 8'h00);
    for (int k = 0; k < 5; k++) apply(8'(k + 1), 2);
    do_stop();
    chk(count == 1, "R4", "only first stored", count, 1);
    readback(0, "R4");

    // R5: every-sample mode with a constant bus
    do_arm(0, 8'hFF);
    apply(8'h3C, 6);
    do_stop();
    chk(count == 6, "R5", "every clock stored", count, 6);
    readback(0, "R5");
    readback(1, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule